// File: doc/BRIEF.md
# Control Endpoint Interrupt Status Register

This block keeps the interrupt-source flags for the control endpoint (endpoint 0) of a USB device. The protocol engine sends single-cycle event strobes. They report a NAK sent to an IN token, an acknowledged transmit, a received data packet, a completed status stage, a stage event and a protocol event. Each strobe sets its flag. Flags are cleared in three ways: firmware writes a zero to the matching bit of a write-only clear port; a new SETUP token arrives; or the endpoint-0 transmit or receive buffer reaches a defined access condition.

The CPU reads the flags as one 8-bit value. An interrupt pulse lasting one cycle goes out whenever a hardware event turns at least one flag from 0 to 1. The block also holds a receive-ready indication. This indication is raised together with the receive-data flag and is dropped only when the receive buffer has been drained. The flags, the pulse and the ready indication are all registered and change on the same clock edge.

Top module: `ep0_int_status`

## Requirements
- R1: A synchronous active-high reset sets the status to 0x00 and drives the interrupt pulse and the receive-ready output to 0.
- R2: Bits 7 and 0 of the status always read 0.
- R3: The IN-NAK strobe sets bit 6, the stage strobe sets bit 2 and the protocol strobe sets bit 1.
- R4: The transmit-acknowledge strobe sets bit 5. A CPU write strobe to the transmit buffer clears bit 5.
- R5: A receive-packet strobe with the zero-length qualifier low sets bit 4 and the receive-ready output. With the qualifier high, both are left unchanged.
- R6: Bit 4 and receive-ready are cleared in a cycle where the receive-read strobe is high and the remaining byte count input equals 0. A read with a nonzero count leaves both unchanged.
- R7: Bit 3 is set by the status-complete strobe or by the zero-length DATA0 status strobe.
- R8: The SETUP strobe clears bits 3 and 2.
- R9: With the clear-write strobe high, every status bit whose clear-data bit is 0 is cleared and every bit whose clear-data bit is 1 is kept. With the strobe low, the clear data has no effect. A clear of bit 4 does not affect receive-ready.
- R10: When a set strobe and any clear condition hit the same bit in one cycle, the bit ends at 1.
- R11: The interrupt output is high for exactly the cycle in which the updated status first shows at least one bit that rose from 0 to 1. Clears alone never raise it.
- R12: Every status and output change appears after the clock edge that samples its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_seen | input | 1 | Strobe: a SETUP token was received |
| in_nak_sent | input | 1 | Strobe: an IN token for endpoint 0 was answered with NAK |
| tx_acked | input | 1 | Strobe: the host acknowledged transmit-buffer data, including zero-length data |
| rx_pkt_ok | input | 1 | Strobe: a data packet was received correctly into the receive buffer |
| rx_pkt_empty | input | 1 | Qualifier for rx_pkt_ok: the packet had zero length |
| status_ok | input | 1 | Strobe: the status stage completed |
| status_zlp0 | input | 1 | Strobe: zero-length DATA0 was received in the status stage |
| stage_evt | input | 1 | Strobe: the stage event |
| proto_evt | input | 1 | Strobe: the protocol event |
| tx_buf_wr | input | 1 | CPU write strobe to the transmit buffer |
| rx_buf_rd | input | 1 | CPU read strobe from the receive buffer |
| rx_left | input | CNT_W | Receive bytes remaining after the current read |
| clr_wr | input | 1 | CPU write strobe to the clear port |
| clr_data | input | STAT_W | Clear-port data; a 0 bit clears the matching status bit |
| status | output | STAT_W | Interrupt status flags |
| irq | output | 1 | One-cycle interrupt pulse |
| rx_ready | output | 1 | Receive-ready indication |

## Verification
The bench targets the cycles where a set and a clear collide on one bit. Examples are an IN-NAK together with a clear-all write, a SETUP together with a status completion, a transmit acknowledge together with a buffer write, and a packet arrival together with a drain. A design that gives the clear priority drops the event and shows neither the flag nor the pulse. It also checks the auto-clears that must not raise an interrupt. A design that compares changes instead of rises would pulse on the drain, on the buffer write and on the SETUP clear. Other cases covered are a zero-length receive and a receive read with bytes still left, where a wrong design would raise or drop the receive flag too early. The last case is a clear write of bit 4, which must leave receive-ready set.

// File: rtl/ep0_stat_pkg.sv
package ep0_stat_pkg;
  localparam int STAT_BITS   = 8;
  localparam int B_IN_NAK    = 6;
  localparam int B_TX_DONE   = 5;
  localparam int B_RX_DATA   = 4;
  localparam int B_CTRL_OK   = 3;
  localparam int B_STAGE     = 2;
  localparam int B_PROTO     = 1;
  localparam logic [STAT_BITS-1:0] LIVE_MASK = 8'b0111_1110;

  typedef struct packed {
    logic in_nak;
    logic tx_done;
    logic rx_data;
    logic ctrl_ok;
    logic stage;
    logic proto;
  } set_evt_t;
endpackage

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] nxt_o,
  output logic [WIDTH-1:0] q_o
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic q_r;
      assign nxt_o[gi] = set_vec[gi] | (q_r & ~clr_vec[gi]);
      always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= nxt_o[gi];
      end
      assign q_o[gi] = q_r;

      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_vec[gi] |=> q_o[gi]);
      // R9
      clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[gi] && !set_vec[gi]) |=> !q_o[gi]);
    end
  endgenerate
endmodule

// File: rtl/ep0_clear_logic.sv
module ep0_clear_logic
  import ep0_stat_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 7
) (
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] clr_data,
  input  logic             setup_seen,
  input  logic             tx_buf_wr,
  input  logic             rx_buf_rd,
  input  logic [CNT_W-1:0] rx_left,
  output logic             rx_drain,
  output logic [WIDTH-1:0] clr_vec
);
  logic [WIDTH-1:0] fw_clr;
  logic [WIDTH-1:0] hw_clr;

  assign rx_drain = rx_buf_rd && (rx_left == '0);
  assign fw_clr   = clr_wr ? ~clr_data : '0;

  always_comb begin
    hw_clr = '0;
    if (setup_seen) begin
      hw_clr[B_CTRL_OK] = 1'b1;
      hw_clr[B_STAGE]   = 1'b1;
    end
    if (tx_buf_wr) hw_clr[B_TX_DONE] = 1'b1;
    if (rx_drain)  hw_clr[B_RX_DATA] = 1'b1;
  end

  assign clr_vec = fw_clr | hw_clr;
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] nxt,
  output logic             irq_o
);
  logic [WIDTH-1:0] rise;
  logic             irq_r;

  assign rise = nxt & ~cur;

  always_ff @(posedge clk) begin
    if (rst) irq_r <= 1'b0;
    else     irq_r <= |rise;
  end

  assign irq_o = irq_r;
endmodule

// File: rtl/ep0_int_status.sv
module ep0_int_status
  import ep0_stat_pkg::*;
#(
  parameter int STAT_W = STAT_BITS,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              setup_seen,
  input  logic              in_nak_sent,
  input  logic              tx_acked,
  input  logic              rx_pkt_ok,
  input  logic              rx_pkt_empty,
  input  logic              status_ok,
  input  logic              status_zlp0,
  input  logic              stage_evt,
  input  logic              proto_evt,
  input  logic              tx_buf_wr,
  input  logic              rx_buf_rd,
  input  logic [CNT_W-1:0]  rx_left,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              rx_ready
);
  set_evt_t          evt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] nxt;
  logic [STAT_W-1:0] cur;
  logic              rx_drain;
  logic              rdy_r;

  always_comb begin
    evt.in_nak  = in_nak_sent;
    evt.tx_done = tx_acked;
    evt.rx_data = rx_pkt_ok && !rx_pkt_empty;
    evt.ctrl_ok = status_ok || status_zlp0;
    evt.stage   = stage_evt;
    evt.proto   = proto_evt;
  end

  always_comb begin
    set_vec            = '0;
    set_vec[B_IN_NAK]  = evt.in_nak;
    set_vec[B_TX_DONE] = evt.tx_done;
    set_vec[B_RX_DATA] = evt.rx_data;
    set_vec[B_CTRL_OK] = evt.ctrl_ok;
    set_vec[B_STAGE]   = evt.stage;
    set_vec[B_PROTO]   = evt.proto;
    set_vec            = set_vec & LIVE_MASK;
  end

  ep0_clear_logic #(.WIDTH(STAT_W), .CNT_W(CNT_W)) u_clr (
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .setup_seen (setup_seen),
    .tx_buf_wr  (tx_buf_wr),
    .rx_buf_rd  (rx_buf_rd),
    .rx_left    (rx_left),
    .rx_drain   (rx_drain),
    .clr_vec    (clr_vec)
  );

  ep0_flag_bank #(.WIDTH(STAT_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .nxt_o   (nxt),
    .q_o     (cur)
  );

  ep0_irq_gen #(.WIDTH(STAT_W)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .cur   (cur),
    .nxt   (nxt),
    .irq_o (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)                rdy_r <= 1'b0;
    else if (evt.rx_data)   rdy_r <= 1'b1;
    else if (rx_drain)      rdy_r <= 1'b0;
  end

  assign status   = cur;
  assign rx_ready = rdy_r;

  logic chk_live;
  always_ff @(posedge clk) begin
    if (rst) chk_live <= 1'b0;
    else     chk_live <= 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status[7] == 1'b0) && (status[0] == 1'b0));
  // R11
  irq_needs_rise_chk: assert property (@(posedge clk) disable iff (rst || !chk_live)
    irq |-> ((status & ~$past(status)) != '0));
  // R11
  rise_gives_irq_chk: assert property (@(posedge clk) disable iff (rst || !chk_live)
    ((status & ~$past(status)) != '0) |-> irq);
  // R8
  setup_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_seen && !status_ok && !status_zlp0 && !stage_evt) |=> (!status[3] && !status[2]));
  // R5
  rdy_follows_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pkt_ok && !rx_pkt_empty) |=> (rx_ready && status[4]));
  // R6
  drain_clears_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_buf_rd && rx_left == '0 && !(rx_pkt_ok && !rx_pkt_empty)) |=> !rx_ready);
endmodule

// File: tb/ep0_int_status_bench.sv
module ep0_int_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       setup_seen, in_nak_sent, tx_acked, rx_pkt_ok, rx_pkt_empty;
  logic       status_ok, status_zlp0, stage_evt, proto_evt;
  logic       tx_buf_wr, rx_buf_rd, clr_wr;
  logic [6:0] rx_left;
  logic [7:0] clr_data;
  logic [7:0] status;
  logic       irq, rx_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep0_int_status u_ep0_int_status (
    .clk(clk), .rst(rst), .setup_seen(setup_seen), .in_nak_sent(in_nak_sent),
    .tx_acked(tx_acked), .rx_pkt_ok(rx_pkt_ok), .rx_pkt_empty(rx_pkt_empty),
    .status_ok(status_ok), .status_zlp0(status_zlp0), .stage_evt(stage_evt),
    .proto_evt(proto_evt), .tx_buf_wr(tx_buf_wr), .rx_buf_rd(rx_buf_rd),
    .rx_left(rx_left), .clr_wr(clr_wr), .clr_data(clr_data),
    .status(status), .irq(irq), .rx_ready(rx_ready)
  );

  // {events[8:0], tx_wr, rx_rd, rx_zero, clr_wr, clr_data, exp_status, exp_irq, exp_rdy}
  // events: [8]setup [7]in_nak [6]tx_ack [5]rx_pkt [4]rx_empty [3]status_ok [2]status_zlp0 [1]stage [0]proto
  localparam logic [30:0] VEC [NV] = '{
    {9'h080, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h40, 1'b1, 1'b0},
    {9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h40, 1'b0, 1'b0},
    {9'h040, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h60, 1'b1, 1'b0},
    {9'h030, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h60, 1'b0, 1'b0},
    {9'h020, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h70, 1'b1, 1'b1},
    {9'h000, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h70, 1'b0, 1'b1},
    {9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h60, 1'b0, 1'b0},
    {9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h40, 1'b0, 1'b0},
    {9'h00A, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h4C, 1'b1, 1'b0},
    {9'h100, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h40, 1'b0, 1'b0},
    {9'h004, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h48, 1'b1, 1'b0},
    {9'h001, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h4A, 1'b1, 1'b0},
    {9'h000, 1'b0, 1'b0, 1'b0, 1'b1, 8'hBF, 8'h0A, 1'b0, 1'b0},
    {9'h080, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h40, 1'b1, 1'b0},
    {9'h000, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h40, 1'b0, 1'b0},
    {9'h108, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h48, 1'b1, 1'b0},
    {9'h040, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h68, 1'b1, 1'b0},
    {9'h020, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h78, 1'b1, 1'b1},
    {9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h78, 1'b0, 1'b1},
    {9'h000, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEF, 8'h68, 1'b0, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:   return "R3";
      2:      return "R4";
      3, 4:   return "R5";
      5, 6:   return "R6";
      7:      return "R4";
      8:      return "R7";
      9:      return "R8";
      10:     return "R7";
      11:     return "R3";
      12, 14, 18, 19: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {setup_seen, in_nak_sent, tx_acked, rx_pkt_ok, rx_pkt_empty} = '0;
    {status_ok, status_zlp0, stage_evt, proto_evt} = '0;
    {tx_buf_wr, rx_buf_rd, clr_wr} = '0;
    rx_left  = 7'd0;
    clr_data = 8'hFF;
  endtask

  task automatic apply(logic [30:0] v);
    {setup_seen, in_nak_sent, tx_acked, rx_pkt_ok, rx_pkt_empty,
     status_ok, status_zlp0, stage_evt, proto_evt} = v[30:22];
    tx_buf_wr = v[21];
    rx_buf_rd = v[20];
    rx_left   = v[19] ? 7'd0 : 7'd5;
    clr_wr    = v[18];
    clr_data  = v[17:10];
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", status, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
    chk("R1", {7'd0, rx_ready}, 8'h00);

    // table walk; R11 and R12 on every row (irq and status sampled after the edge)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(posedge clk);
      #1;
      chk(tag_of(i), status, VEC[i][9:2]);
      chk({tag_of(i), "/R11"}, {7'd0, irq}, {7'd0, VEC[i][1]});
      chk({tag_of(i), "/R12"}, {7'd0, rx_ready}, {7'd0, VEC[i][0]});
      chk("R2", status & 8'h81, 8'h00);
      @(negedge clk);
      idle();
    end

    // R11 pulse lasts one cycle
    @(posedge clk);
    #1;
    chk("R11", {7'd0, irq}, 8'h00);

    // R2: clear port written with all ones and every event fired
    @(negedge clk);
    {setup_seen, in_nak_sent, tx_acked, rx_pkt_ok, status_ok, stage_evt, proto_evt} = '1;
    @(posedge clk);
    #1;
    chk("R2", status, 8'h7E);
    @(negedge clk);
    idle();

    // R1: reset wins over a simultaneous event
    rst = 1'b1;
    in_nak_sent = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", status, 8'h00);
    chk("R1", {6'd0, irq, rx_ready}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    idle();
    @(negedge clk);
    chk("R1", status, 8'h00);

    done = 1'b1;
    finish_run();
  end
endmodule